// File: doc/BRIEF.md
# Transmit Request Flag Controller

This block keeps two flags for each of a small set of CAN message buffers: a pending-transmit flag and a fresh-data flag. Software sets or clears both flags of one buffer at a time through a plain write port. The block offers the lowest-numbered pending buffer to the protocol core over a valid/ready handshake. The core then reports whether that attempt succeeded or failed, and the block updates the flags of that buffer. Framing, arbitration and acceptance filtering stay in the core. Here they show up only as these events.

A mode pin chooses how failures are handled. With `no_retry` low, a buffer stays pending through failed attempts and is offered again until it is sent. With `no_retry` high, the pending flag drops when the attempt starts. The fresh-data flag then records the outcome: a success clears it and a failure leaves it set. A buffer that fails in this mode is not sent again until software sets its pending flag once more.

Back-pressure rules for the offer channel: `offer_valid` and `offer_idx` are driven from registered state. While `offer_ready` is low they hold steady, unless a software write changes the pending set. A transfer takes place on a clock edge where both `offer_valid` and `offer_ready` are high, and that transfer is the start of transmission. Only one buffer can be in flight at a time, so `offer_valid` stays low until the core ends the attempt.

Top module: `tx_req_ctrl`

## Requirements
- R1: After reset, all pending flags and fresh-data flags are 0, `busy` is 0 and `offer_valid` is 0.
- R2: A write (`cpu_we`=1) to a buffer that is not in flight loads `cpu_req` into its pending flag and `cpu_nd` into its fresh-data flag at that clock edge. The flags appear on `txreq_o`/`newdat_o`, where bit i belongs to buffer i.
- R3: When nothing is in flight and any pending flag is set, `offer_valid` is 1 and `offer_idx` is the lowest-numbered pending buffer.
- R4: A handshake (`offer_valid` and `offer_ready` both 1) puts the offered buffer in flight from the next cycle: `busy`=1 and `busy_idx` is the index. While busy, `offer_valid` is 0. While `offer_ready` is low, the offer holds steady.
- R5: With `no_retry`=1, the handshake clears the pending flag of the started buffer and leaves its fresh-data flag unchanged.
- R6: `end_ok` with `end_idx` equal to the in-flight buffer clears that buffer's pending and fresh-data flags and clears `busy`, in either mode.
- R7: With `no_retry`=1, `end_fail` for the in-flight buffer clears `busy` and leaves fresh-data set and pending clear. The buffer is not offered again until a write sets its pending flag.
- R8: With `no_retry`=0, `end_fail` for the in-flight buffer clears `busy` and leaves both flags set, so the buffer is offered again.
- R9: A write to the buffer that is in flight, or that is being started in the same cycle, changes neither of its flags.
- R10: An `end_ok` or `end_fail` whose `end_idx` does not match the in-flight buffer, or that arrives while nothing is in flight, changes no flag and does not change `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| no_retry | input | 1 | 1 = automatic retransmission disabled |
| cpu_we | input | 1 | Flag write strobe |
| cpu_idx | input | IDXW | Buffer addressed by the write |
| cpu_req | input | 1 | Value written to the pending flag |
| cpu_nd | input | 1 | Value written to the fresh-data flag |
| offer_valid | output | 1 | A buffer is offered for transmission |
| offer_idx | output | IDXW | Offered buffer |
| offer_ready | input | 1 | Core starts sending the offered buffer |
| end_ok | input | 1 | Attempt completed successfully |
| end_fail | input | 1 | Attempt failed (arbitration loss or error) |
| end_idx | input | IDXW | Buffer the end event refers to |
| busy | output | 1 | A buffer is in flight |
| busy_idx | output | IDXW | Buffer in flight |
| txreq_o | output | NBUF | Pending flags, bit i = buffer i |
| newdat_o | output | NBUF | Fresh-data flags, bit i = buffer i |

## Verification
Every flag change, as well as `busy` and `busy_idx`, is registered. Each one becomes visible one cycle after the edge that sampled the write, the handshake or the end event. `offer_valid` and `offer_idx` are combinational from those registers, so they follow the same edge with no further delay. The bench changes inputs just after a rising edge. It checks every result just after the next rising edge, which is the first point where the effect is due. For a result that must not change, it checks at that same point and again after further idle cycles.

// File: rtl/tx_req_pkg.sv
package tx_req_pkg;
  typedef enum logic [1:0] {
    END_NONE = 2'd0,
    END_OK   = 2'd1,
    END_FAIL = 2'd2
  } end_kind_e;
endpackage

// File: rtl/txr_pick.sv
module txr_pick #(
  parameter int NBUF = 8,
  parameter int IDXW = 3
) (
  input  logic [NBUF-1:0] req_i,
  output logic            found_o,
  output logic [IDXW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/txr_flight.sv
module txr_flight
  import tx_req_pkg::*;
#(
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [IDXW-1:0] start_idx_i,
  input  logic            end_ok_i,
  input  logic            end_fail_i,
  input  logic [IDXW-1:0] end_idx_i,
  output logic            busy_o,
  output logic [IDXW-1:0] busy_idx_o,
  output end_kind_e       end_kind_o
);
  logic match;
  assign match = busy_o && (end_idx_i == busy_idx_o);

  always_comb begin
    end_kind_o = END_NONE;
    if (match && end_ok_i)        end_kind_o = END_OK;
    else if (match && end_fail_i) end_kind_o = END_FAIL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o     <= 1'b0;
      busy_idx_o <= '0;
    end else if (start_i) begin
      busy_o     <= 1'b1;
      busy_idx_o <= start_idx_i;
    end else if (end_kind_o != END_NONE) begin
      busy_o     <= 1'b0;
    end
  end

  // R10: an event that does not match keeps the flight state
  a_r10_mismatch_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && (end_ok_i || end_fail_i) && end_idx_i != busy_idx_o) |=> busy_o);
  // R4: a start is only accepted while idle
  a_r4_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);
endmodule

// File: rtl/txr_flag_cell.sv
module txr_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic wr_req_i,
  input  logic wr_nd_i,
  input  logic start_i,
  input  logic no_retry_i,
  input  logic ok_i,
  output logic req_o,
  output logic nd_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_o <= 1'b0;
      nd_o  <= 1'b0;
    end else if (ok_i) begin
      req_o <= 1'b0;
      nd_o  <= 1'b0;
    end else if (start_i) begin
      if (no_retry_i) req_o <= 1'b0;
    end else if (wr_i) begin
      req_o <= wr_req_i;
      nd_o  <= wr_nd_i;
    end
  end

  // R5: dropping the pending flag at start leaves fresh-data alone
  a_r5_nd_kept_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !ok_i) |=> nd_o == $past(nd_o));
endmodule

// File: rtl/tx_req_ctrl.sv
module tx_req_ctrl
  import tx_req_pkg::*;
#(
  parameter int NBUF = 8,
  parameter int IDXW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            no_retry,
  input  logic            cpu_we,
  input  logic [IDXW-1:0] cpu_idx,
  input  logic            cpu_req,
  input  logic            cpu_nd,
  output logic            offer_valid,
  output logic [IDXW-1:0] offer_idx,
  input  logic            offer_ready,
  input  logic            end_ok,
  input  logic            end_fail,
  input  logic [IDXW-1:0] end_idx,
  output logic            busy,
  output logic [IDXW-1:0] busy_idx,
  output logic [NBUF-1:0] txreq_o,
  output logic [NBUF-1:0] newdat_o
);
  logic      found;
  logic      hs;
  logic      blocked;
  end_kind_e end_kind;

  txr_pick #(.NBUF(NBUF), .IDXW(IDXW)) u_pick (
    .req_i(txreq_o), .found_o(found), .idx_o(offer_idx)
  );

  assign offer_valid = found && !busy;
  assign hs          = offer_valid && offer_ready;
  assign blocked     = (busy && cpu_idx == busy_idx) || (hs && cpu_idx == offer_idx);

  txr_flight #(.IDXW(IDXW)) u_flight (
    .clk(clk), .rst_n(rst_n),
    .start_i(hs), .start_idx_i(offer_idx),
    .end_ok_i(end_ok), .end_fail_i(end_fail), .end_idx_i(end_idx),
    .busy_o(busy), .busy_idx_o(busy_idx), .end_kind_o(end_kind)
  );

  for (genvar i = 0; i < NBUF; i++) begin : g_buf
    logic sel_wr, sel_start, sel_ok;
    assign sel_wr    = cpu_we && !blocked && (cpu_idx == IDXW'(i));
    assign sel_start = hs && (offer_idx == IDXW'(i));
    assign sel_ok    = (end_kind == END_OK) && (busy_idx == IDXW'(i));
    txr_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .wr_i(sel_wr), .wr_req_i(cpu_req), .wr_nd_i(cpu_nd),
      .start_i(sel_start), .no_retry_i(no_retry), .ok_i(sel_ok),
      .req_o(txreq_o[i]), .nd_o(newdat_o[i])
    );
  end

  // R3: no pending buffer below the offered one
  a_r3_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |-> (txreq_o & ((NBUF'(1) << offer_idx) - NBUF'(1))) == '0);
  // R4: nothing is offered while a buffer is in flight
  a_r4_no_offer_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !offer_valid);
  // R5: start in no-retry mode drops the pending flag
  a_r5_drop_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && no_retry) |=> !txreq_o[$past(offer_idx)]);
  // R6: success clears the fresh-data flag and the flight
  a_r6_clear_on_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && end_ok && end_idx == busy_idx) |=> (!newdat_o[$past(end_idx)] && !busy));
  // R10: events while idle touch no flag
  a_r10_idle_event: assert property (@(posedge clk) disable iff (!rst_n)
    ((end_ok || end_fail) && !busy && !cpu_we) |=> $stable(newdat_o));
  // R9: a write to the in-flight buffer is not taken
  a_r9_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cpu_we && cpu_idx == busy_idx && !(end_ok && end_idx == busy_idx))
      |=> newdat_o[$past(cpu_idx)] == $past(newdat_o[cpu_idx]));
endmodule

// File: tb/tx_req_ctrl_tb.sv
module tx_req_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int NBUF  = 8;
  localparam int IDXW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic no_retry = 1'b0, cpu_we = 1'b0, cpu_req = 1'b0, cpu_nd = 1'b0;
  logic [IDXW-1:0] cpu_idx = '0, end_idx = '0;
  logic offer_ready = 1'b0, end_ok = 1'b0, end_fail = 1'b0;
  logic offer_valid, busy;
  logic [IDXW-1:0] offer_idx, busy_idx;
  logic [NBUF-1:0] txreq_o, newdat_o;

  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  tx_req_ctrl #(.NBUF(NBUF)) u_dut (
    .clk(clk), .rst_n(rst_n), .no_retry(no_retry),
    .cpu_we(cpu_we), .cpu_idx(cpu_idx), .cpu_req(cpu_req), .cpu_nd(cpu_nd),
    .offer_valid(offer_valid), .offer_idx(offer_idx), .offer_ready(offer_ready),
    .end_ok(end_ok), .end_fail(end_fail), .end_idx(end_idx),
    .busy(busy), .busy_idx(busy_idx), .txreq_o(txreq_o), .newdat_o(newdat_o)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step(); @(posedge clk); #1; endtask

  task automatic wr(input int idx, input bit rq, input bit nd);
    cpu_we = 1; cpu_idx = IDXW'(idx); cpu_req = rq; cpu_nd = nd;
    step();
    cpu_we = 0;
  endtask

  task automatic start(); offer_ready = 1; step(); offer_ready = 0; endtask

  task automatic fin(input bit ok, input int idx);
    end_ok = ok; end_fail = !ok; end_idx = IDXW'(idx);
    step();
    end_ok = 0; end_fail = 0;
  endtask

  task automatic t_reset();
    check("R1 txreq", int'(txreq_o), 0);
    check("R1 newdat", int'(newdat_o), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 offer_valid", int'(offer_valid), 0);
  endtask

  task automatic t_write_pick();
    wr(5, 1, 1);
    check("R2 txreq", int'(txreq_o), 'h20);
    check("R2 newdat", int'(newdat_o), 'h20);
    check("R3 offer idx 5", int'(offer_idx), 5);
    wr(2, 1, 1);
    check("R3 offer valid", int'(offer_valid), 1);
    check("R3 lowest idx 2", int'(offer_idx), 2);
  endtask

  task automatic t_backpressure();
    step(); step();
    check("R4 hold valid", int'(offer_valid), 1);
    check("R4 hold idx", int'(offer_idx), 2);
  endtask

  task automatic t_normal_ok();
    no_retry = 0;
    start();
    check("R4 busy", int'(busy), 1);
    check("R4 busy_idx", int'(busy_idx), 2);
    check("R4 no offer", int'(offer_valid), 0);
    check("R4 req kept", int'(txreq_o), 'h24);
    fin(1, 2);
    check("R6 txreq", int'(txreq_o), 'h20);
    check("R6 newdat", int'(newdat_o), 'h20);
    check("R6 busy", int'(busy), 0);
    check("R3 next offer", int'(offer_idx), 5);
  endtask

  task automatic t_normal_fail();
    start();
    fin(0, 5);
    check("R8 busy", int'(busy), 0);
    check("R8 txreq", int'(txreq_o), 'h20);
    check("R8 newdat", int'(newdat_o), 'h20);
    check("R8 reoffer", int'(offer_valid && offer_idx == 5), 1);
    start();
    fin(1, 5);
    check("R6 cleared", int'(txreq_o | newdat_o), 0);
  endtask

  task automatic t_ignore();
    wr(0, 0, 1);
    fin(1, 0);
    check("R10 idle ok", int'(newdat_o), 'h01);
    check("R10 idle busy", int'(busy), 0);
    wr(1, 1, 1);
    start();
    fin(1, 3);
    check("R10 mismatch busy", int'(busy), 1);
    fin(0, 3);
    check("R10 mismatch flags", int'(txreq_o), 'h02);
    wr(1, 0, 0);
    check("R9 req kept", int'(txreq_o), 'h02);
    check("R9 nd kept", int'(newdat_o), 'h03);
    fin(1, 1);
    check("R6 after ignore", int'(newdat_o), 'h01);
    wr(0, 0, 0);
  endtask

  task automatic t_no_retry();
    no_retry = 1;
    wr(3, 1, 1);
    start();
    check("R5 req dropped", int'(txreq_o), 0);
    check("R5 nd kept", int'(newdat_o), 'h08);
    fin(0, 3);
    check("R7 busy", int'(busy), 0);
    check("R7 nd set", int'(newdat_o), 'h08);
    step(); step();
    check("R7 not offered", int'(offer_valid), 0);
    wr(3, 1, 1);
    check("R7 reoffer", int'(offer_valid && offer_idx == 3), 1);
    start();
    fin(1, 3);
    check("R6 nd cleared", int'(newdat_o), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        step();
        t_reset();
        t_write_pick();
        t_backpressure();
        t_normal_ok();
        t_normal_fail();
        t_ignore();
        t_no_retry();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule